// File: doc/BRIEF.md
# Periodic Memory Traffic Generator

This block acts as an extra master on a shared memory port. Its only job is to use up bandwidth. A free-running interval timer marks time slots of a fixed length. At each slot the generator issues one burst request of a fixed size, provided no earlier burst is still in flight. The direction is fixed for each instance: a write instance sends its own data beats after the grant, and a read instance accepts the returned beats and throws them away. To load a memory in both directions, place two instances.

The byte count per burst, the slot length in clock cycles, the number of bursts and the direction are all parameters. For example, 192-byte bursts repeated 1,296,000 times a second use about 248.8 MB/s. A burst total of zero means the traffic never stops. The timer keeps its own pace, so a memory that is too busy to serve this master shows up as slots that found the generator still occupied. The block counts these slots as late bursts, and they reduce the throughput the master achieves. It also counts completed bursts, and in finite mode it raises a done flag.

Controller states:
- IDLE: waiting for a slot.
- REQUEST: command held until it is granted.
- WRITE: beats being sent.
- READ: returned beats being drained.
- CLOSE: one cycle that books the finished burst.

Transitions:
- IDLE→REQUEST on a slot while enabled and below the total.
- REQUEST→WRITE or REQUEST→READ on grant, according to the direction parameter.
- WRITE→CLOSE when the final beat is accepted.
- READ→CLOSE when a beat marked last is accepted.
- CLOSE→IDLE always.

Top module: `bw_load_gen`

## Requirements
- R1: While reset is asserted, req_valid, wr_valid, rd_ready, busy and done are 0, and both counters read 0.
- R2: While enabled and never late, each request rises exactly PERIOD_CYCLES clock cycles after the previous one.
- R3: Once raised, req_valid stays high with a stable req_addr until a cycle with req_gnt high. Only one burst is outstanding at a time, and no request is shown during data transfer.
- R4: The n-th request (counting from 0) carries req_addr = BASE_ADDR + n*BURST_BYTES and req_len = BURST_BYTES/BEAT_BYTES beats (24 by default). req_write is 1 for a write instance and 0 for a read instance.
- R5: After a write grant, exactly req_len beats are sent. The upper half of wr_data holds the burst index n and the lower half holds the beat index 0..req_len-1. wr_last is high on the final beat only.
- R6: After a read grant, rd_ready stays high until a beat with rd_last is accepted, and is low in the following cycle.
- R7: bursts_done rises by exactly one for each completed burst.
- R8: A slot that ends while busy is high adds one to bursts_late and does not produce a request.
- R9: With BURST_TOTAL > 0, done goes high after BURST_TOTAL bursts, and no further request is ever issued.
- R10: With BURST_TOTAL = 0, done stays low and requests continue for as long as enable is high.
- R11: When enable falls during a burst, that burst completes, no new request is made while enable is low, and the slot timer starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new bursts to start |
| req_valid | output | 1 | Burst command pending |
| req_write | output | 1 | Burst direction, 1 = write |
| req_addr | output | ADDR_W | Burst start address |
| req_len | output | LEN_W | Beats in the burst |
| req_gnt | input | 1 | Command accepted this cycle |
| wr_valid | output | 1 | Write beat available |
| wr_data | output | DATA_W | Write beat payload |
| wr_last | output | 1 | Final write beat |
| wr_ready | input | 1 | Write beat accepted this cycle |
| rd_valid | input | 1 | Read beat offered |
| rd_last | input | 1 | Final read beat |
| rd_ready | output | 1 | Read beats are being drained |
| busy | output | 1 | A burst is in flight |
| done | output | 1 | Finite total reached |
| bursts_done | output | CNT_W | Completed burst count |
| bursts_late | output | CNT_W | Late slot count |

## Verification
The properties assume that the responder asserts req_gnt only as a single-cycle pulse against a pending request. They also assume that read beats are offered only while rd_ready is high, with rd_last on exactly one of them. The bench's responders keep to this. The write-side responder grants after a fixed latency. The read-side responder alternates a short latency with a 40-cycle latency, and that long latency is what forces late slots. Ready and valid are gated by cycle-count patterns, so transfers stall at varying points within a burst.

// File: rtl/bwgen_pkg.sv
package bwgen_pkg;

    typedef enum logic [2:0] {
        GEN_IDLE,
        GEN_REQUEST,
        GEN_WRITE,
        GEN_READ,
        GEN_CLOSE
    } gen_state_e;

endpackage

// File: rtl/bwgen_pacer.sv
// Free-running slot timer: pulses once per PERIOD cycles while run is high.
module bwgen_pacer #(
    parameter int PERIOD = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    logic [TW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = run && (phase_q == LAST);

endmodule

// File: rtl/bwgen_tally.sv
// Completed and late burst counters, plus the finite-total limit.
module bwgen_tally #(
    parameter int CNT_W       = 16,
    parameter int BURST_TOTAL = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_end,
    input  logic             late_hit,
    output logic [CNT_W-1:0] bursts,
    output logic [CNT_W-1:0] lates,
    output logic             limit_hit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bursts <= '0;
            lates  <= '0;
        end else begin
            if (burst_end) bursts <= bursts + 1'b1;
            if (late_hit)  lates  <= lates + 1'b1;
        end
    end

    generate
        if (BURST_TOTAL == 0) begin : g_unlimited
            assign limit_hit = 1'b0;
        end else begin : g_finite
            assign limit_hit = (bursts == CNT_W'(BURST_TOTAL));
        end
    endgenerate

endmodule

// File: rtl/bwgen_ctrl.sv
// Burst state machine: one outstanding command, then a beat phase per direction.
module bwgen_ctrl
    import bwgen_pkg::*;
#(
    parameter int BEATS    = 24,
    parameter int BEAT_W   = 5,
    parameter bit IS_WRITE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic              limit_hit,
    input  logic              req_gnt,
    input  logic              wr_ready,
    input  logic              rd_valid,
    input  logic              rd_last,
    output logic              req_valid,
    output logic              wr_valid,
    output logic              wr_last,
    output logic              rd_ready,
    output logic              burst_end,
    output logic              late_hit,
    output logic              busy,
    output logic [BEAT_W-1:0] beat
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    gen_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GEN_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GEN_IDLE: begin
                if (tick && enable && !limit_hit) st_d = GEN_REQUEST;
            end
            GEN_REQUEST: begin
                if (req_gnt) begin
                    if (IS_WRITE) st_d = GEN_WRITE;
                    else          st_d = GEN_READ;
                end
            end
            GEN_WRITE: begin
                if (wr_ready && beat == LAST_BEAT) st_d = GEN_CLOSE;
            end
            GEN_READ: begin
                if (rd_valid && rd_last) st_d = GEN_CLOSE;
            end
            GEN_CLOSE: st_d = GEN_IDLE;
            default:   st_d = GEN_IDLE;
        endcase
    end

    always_comb begin
        req_valid = 1'b0;
        wr_valid  = 1'b0;
        rd_ready  = 1'b0;
        burst_end = 1'b0;
        busy      = 1'b1;
        unique case (st_q)
            GEN_IDLE:    busy      = 1'b0;
            GEN_REQUEST: req_valid = 1'b1;
            GEN_WRITE:   wr_valid  = 1'b1;
            GEN_READ:    rd_ready  = 1'b1;
            GEN_CLOSE:   burst_end = 1'b1;
            default:     busy      = 1'b0;
        endcase
        wr_last  = wr_valid && (beat == LAST_BEAT);
        late_hit = tick && busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (st_q == GEN_WRITE && wr_ready) begin
            beat <= (beat == LAST_BEAT) ? '0 : beat + 1'b1;
        end
    end

endmodule

// File: rtl/bw_load_gen.sv
module bw_load_gen
    import bwgen_pkg::*;
#(
    parameter int BURST_BYTES   = 192,
    parameter int BEAT_BYTES    = 8,
    parameter int PERIOD_CYCLES = 64,
    parameter int BURST_TOTAL   = 5,
    parameter bit IS_WRITE      = 1'b1,
    parameter int ADDR_W        = 32,
    parameter int CNT_W         = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(32'h0004_0000),
    localparam int BEATS  = BURST_BYTES / BEAT_BYTES,
    localparam int LEN_W  = $clog2(BEATS + 1),
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int DATA_W = BEAT_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    input  logic              req_gnt,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last,
    input  logic              wr_ready,
    input  logic              rd_valid,
    input  logic              rd_last,
    output logic              rd_ready,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  bursts_done,
    output logic [CNT_W-1:0]  bursts_late
);
    localparam int HALF = DATA_W / 2;

    logic              tick;
    logic              burst_end;
    logic              late_hit;
    logic [BEAT_W-1:0] beat;

    bwgen_pacer #(.PERIOD(PERIOD_CYCLES)) u_pacer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (enable && !done),
        .tick (tick)
    );

    bwgen_ctrl #(.BEATS(BEATS), .BEAT_W(BEAT_W), .IS_WRITE(IS_WRITE)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .enable   (enable),
        .limit_hit(done),
        .req_gnt  (req_gnt),
        .wr_ready (wr_ready),
        .rd_valid (rd_valid),
        .rd_last  (rd_last),
        .req_valid(req_valid),
        .wr_valid (wr_valid),
        .wr_last  (wr_last),
        .rd_ready (rd_ready),
        .burst_end(burst_end),
        .late_hit (late_hit),
        .busy     (busy),
        .beat     (beat)
    );

    bwgen_tally #(.CNT_W(CNT_W), .BURST_TOTAL(BURST_TOTAL)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .burst_end(burst_end),
        .late_hit (late_hit),
        .bursts   (bursts_done),
        .lates    (bursts_late),
        .limit_hit(done)
    );

    // Running start address, advanced as each burst closes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         req_addr <= BASE_ADDR;
        else if (burst_end) req_addr <= req_addr + ADDR_W'(BURST_BYTES);
    end

    assign req_write = IS_WRITE;
    assign req_len   = LEN_W'(BEATS);

    generate
        if (IS_WRITE) begin : g_wr_payload
            assign wr_data = {HALF'(bursts_done), HALF'(beat)};
        end else begin : g_rd_only
            assign wr_data = '0;
        end
    endgenerate

endmodule

// File: rtl/bwgen_checker.sv
module bwgen_checker #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 16,
    parameter int BURST_TOTAL = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_gnt,
    input logic [ADDR_W-1:0] req_addr,
    input logic              wr_valid,
    input logic              wr_last,
    input logic              rd_ready,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  bursts_done,
    input logic [CNT_W-1:0]  bursts_late
);
    assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_gnt) |=> (req_valid && $stable(req_addr)));

    assert_single_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !(wr_valid || rd_ready));

    assert_last_in_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_last |-> wr_valid);

    assert_step_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bursts_done != $past(bursts_done)) |-> (bursts_done == $past(bursts_done) + 1'b1));

    assert_late_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bursts_late != $past(bursts_late)) |-> $past(busy));

    assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);

    generate
        if (BURST_TOTAL == 0) begin : g_endless
            assert_never_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !done);
        end
    endgenerate

endmodule

bind bw_load_gen bwgen_checker #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .BURST_TOTAL(BURST_TOTAL)
) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_gnt    (req_gnt),
    .req_addr   (req_addr),
    .wr_valid   (wr_valid),
    .wr_last    (wr_last),
    .rd_ready   (rd_ready),
    .busy       (busy),
    .done       (done),
    .bursts_done(bursts_done),
    .bursts_late(bursts_late)
);

// File: tb/tb_bw_load_gen.sv
module tb_bw_load_gen;
    localparam int CLK_PERIOD = 10;
    localparam int W_PER  = 64;
    localparam int W_TOT  = 5;
    localparam int R_PER  = 48;
    localparam int BEATS  = 24;
    localparam int W_LAT  = 3;
    localparam logic [31:0] W_BASE = 32'h0004_0000;
    localparam logic [31:0] R_BASE = 32'h0008_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // write instance
    logic        w_en = 1'b0, w_gnt = 1'b0, w_rdy = 1'b0;
    logic        w_req, w_wr, w_wv, w_wl, w_rr, w_busy, w_done;
    logic [31:0] w_addr;
    logic [4:0]  w_len;
    logic [63:0] w_wd;
    logic [15:0] w_nb, w_nl;

    bw_load_gen #(.PERIOD_CYCLES(W_PER), .BURST_TOTAL(W_TOT), .IS_WRITE(1'b1), .BASE_ADDR(W_BASE)) dut (
        .clk(clk), .rst_n(rst_n), .enable(w_en),
        .req_valid(w_req), .req_write(w_wr), .req_addr(w_addr), .req_len(w_len), .req_gnt(w_gnt),
        .wr_valid(w_wv), .wr_data(w_wd), .wr_last(w_wl), .wr_ready(w_rdy),
        .rd_valid(1'b0), .rd_last(1'b0), .rd_ready(w_rr),
        .busy(w_busy), .done(w_done), .bursts_done(w_nb), .bursts_late(w_nl));

    // read instance, unlimited
    logic        r_en = 1'b0, r_gnt = 1'b0, r_vld = 1'b0, r_lst = 1'b0;
    logic        r_req, r_wr, r_wv, r_wl, r_rr, r_busy, r_done;
    logic [31:0] r_addr;
    logic [4:0]  r_len;
    logic [63:0] r_wd;
    logic [15:0] r_nb, r_nl;

    bw_load_gen #(.PERIOD_CYCLES(R_PER), .BURST_TOTAL(0), .IS_WRITE(1'b0), .BASE_ADDR(R_BASE)) dut_rd (
        .clk(clk), .rst_n(rst_n), .enable(r_en),
        .req_valid(r_req), .req_write(r_wr), .req_addr(r_addr), .req_len(r_len), .req_gnt(r_gnt),
        .wr_valid(r_wv), .wr_data(r_wd), .wr_last(r_wl), .wr_ready(1'b0),
        .rd_valid(r_vld), .rd_last(r_lst), .rd_ready(r_rr),
        .busy(r_busy), .done(r_done), .bursts_done(r_nb), .bursts_late(r_nl));

    // write responder, driver pushes expected beats, monitor pops them
    logic [63:0] w_q[$];
    logic [31:0] w_addr_seen = '0;
    int w_wait = 0, w_n = 0, w_rises = 0;
    longint w_last_rise = 0;
    bit w_req_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (w_req && !w_req_prev) begin
                if (w_rises > 0)
                    chk(cyc - w_last_rise == W_PER, "R2", 64'(cyc - w_last_rise), 64'(W_PER));
                w_last_rise = cyc;
                w_rises++;
            end
            w_req_prev = w_req;
            if (w_wait != 0 && !w_gnt && !w_req)
                chk(1'b0, "R3", 64'(w_req), 64'd1);
            if (w_gnt) begin
                w_gnt = 1'b0;
            end else if (w_req) begin
                if (w_wait == 0) w_addr_seen = w_addr;
                if (w_wait == W_LAT) begin
                    chk(w_addr == w_addr_seen, "R3", 64'(w_addr), 64'(w_addr_seen));
                    chk(w_addr == W_BASE + 32'(w_n * 192), "R4", 64'(w_addr), 64'(W_BASE + 32'(w_n * 192)));
                    chk(w_len == 5'd24, "R4", 64'(w_len), 64'd24);
                    chk(w_wr == 1'b1, "R4", 64'(w_wr), 64'd1);
                    for (int k = 0; k < BEATS; k++) w_q.push_back({32'(w_n), 32'(k)});
                    w_n++;
                    w_gnt = 1'b1;
                    w_wait = 0;
                end else begin
                    w_wait++;
                end
            end
            w_rdy = (cyc % 7) != 3;
            if (w_wv && w_rdy) begin
                if (w_q.size() == 0) begin
                    chk(1'b0, "R5", w_wd, 64'd0);
                end else begin
                    logic [63:0] e;
                    e = w_q.pop_front();
                    chk(w_wd == e, "R5", w_wd, e);
                    chk(w_wl == (w_q.size() == 0), "R5", 64'(w_wl), 64'(w_q.size() == 0));
                end
            end
        end
    end

    // read responder
    int r_wait = 0, r_n = 0, r_left = 0, r_seen = 0, r_rises = 0;
    bit r_req_prev = 1'b0, r_after_last = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            int lat;
            if (r_req && !r_req_prev) r_rises++;
            r_req_prev = r_req;
            if (r_after_last) begin
                chk(!r_rr, "R6", 64'(r_rr), 64'd0);
                r_after_last = 1'b0;
            end
            lat = (r_n % 3 == 1) ? 40 : 2;
            if (r_gnt) begin
                r_gnt = 1'b0;
            end else if (r_req) begin
                if (r_wait == lat) begin
                    chk(r_addr == R_BASE + 32'(r_n * 192), "R4", 64'(r_addr), 64'(R_BASE + 32'(r_n * 192)));
                    chk(r_wr == 1'b0, "R4", 64'(r_wr), 64'd0);
                    r_gnt = 1'b1;
                    r_wait = 0;
                    r_left = BEATS;
                    r_n++;
                end else begin
                    r_wait++;
                end
            end
            if (r_vld) begin
                r_left--;
                if (r_lst) begin
                    r_seen++;
                    r_after_last = 1'b1;
                end
            end
            r_vld = (r_left != 0) && r_rr && (cyc % 8 != 0);
            r_lst = r_vld && (r_left == 1);
        end
    end

    // expected late-slot counts, sampled just after the falling edge
    int w_ph = 0, r_ph = 0, w_exp_late = 0, r_exp_late = 0;
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (w_en && !w_done) begin
                if (w_ph == W_PER - 1) begin
                    if (w_busy) w_exp_late++;
                    w_ph = 0;
                end else w_ph++;
            end else w_ph = 0;
            if (r_en && !r_done) begin
                if (r_ph == R_PER - 1) begin
                    if (r_busy) r_exp_late++;
                    r_ph = 0;
                end else r_ph++;
            end else r_ph = 0;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int b0, rises0;
        repeat (3) @(negedge clk);
        chk(!w_req && !w_wv && !w_busy && !w_done, "R1", 64'({w_req, w_wv, w_busy, w_done}), 64'd0);
        chk(w_nb == 0 && w_nl == 0, "R1", 64'({w_nb, w_nl}), 64'd0);
        chk(!r_req && !r_rr && !r_busy && !r_done, "R1", 64'({r_req, r_rr, r_busy, r_done}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        w_en = 1'b1;
        r_en = 1'b1;

        for (int i = 0; i < 1000 && !w_done; i++) @(negedge clk);
        chk(w_done, "R9", 64'(w_done), 64'd1);
        chk(w_nb == 16'(W_TOT), "R7", 64'(w_nb), 64'(W_TOT));
        repeat (200) @(negedge clk);
        chk(w_rises == W_TOT, "R9", 64'(w_rises), 64'(W_TOT));
        chk(!w_req, "R9", 64'(w_req), 64'd0);
        chk(w_q.size() == 0, "R5", 64'(w_q.size()), 64'd0);
        chk(w_nl == 16'(w_exp_late), "R8", 64'(w_nl), 64'(w_exp_late));
        chk(w_nl == 0, "R2", 64'(w_nl), 64'd0);

        while (r_left == 0) @(negedge clk);
        b0 = int'(r_nb);
        rises0 = r_rises;
        r_en = 1'b0;
        repeat (150) @(negedge clk);
        chk(int'(r_nb) == b0 + 1, "R11", 64'(r_nb), 64'(b0 + 1));
        chk(r_rises == rises0, "R11", 64'(r_rises), 64'(rises0));
        chk(!r_busy, "R11", 64'(r_busy), 64'd0);
        r_en = 1'b1;
        repeat (600) @(negedge clk);
        r_en = 1'b0;
        repeat (150) @(negedge clk);
        chk(int'(r_nb) == r_seen, "R6", 64'(r_nb), 64'(r_seen));
        chk(int'(r_nb) == r_n, "R7", 64'(r_nb), 64'(r_n));
        chk(r_nl == 16'(r_exp_late), "R8", 64'(r_nl), 64'(r_exp_late));
        chk(r_nl > 0, "R8", 64'(r_nl), 64'd1);
        chk(!r_done, "R10", 64'(r_done), 64'd0);
        chk(r_nb > 10, "R10", 64'(r_nb), 64'd11);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule